// File: doc/BRIEF.md
# Open-Lamp Fault Detector

This block decides when a lamp driver channel has lost its lamp. Once per switching cycle, a comparator outside the block reports whether the tank-sense voltage fell further below the supply than the open-lamp limit. That limit is a drop of roughly 7.8 V. The comparator result arrives as one digital bit, qualified by a per-cycle strobe.

The block feeds these results into a saturating up/down counter. A cycle whose result shows a crossing moves the count up, and a cycle whose result shows no crossing moves it down. A dip now and then therefore decays away. Only a long run in which crossings outnumber quiet cycles drives the count past its top value. When that happens the block latches a fault and asserts a shutdown for the output stage.

A detector-enable qualifier keeps the count at zero while the lamp is igniting. The latched fault clears only through power-on reset.

Top module: `olp_guard`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the count goes to zero and `fault_o` and `shutdown_o` both go low.
- R2: A clock edge with `det_en`=1, `cyc_stb`=1 and `thr_cross`=1 raises the count by one. The count is 4 bits wide by default.
- R3: A clock edge with `det_en`=1, `cyc_stb`=1 and `thr_cross`=0 lowers the count by one. At zero the count stays at zero.
- R4: A clock edge with `det_en`=0 forces the count to zero. This does not clear a latched fault.
- R5: A crossing strobe that arrives while the count is at its maximum (15) sets `fault_o` at that edge, and the count does not wrap. `fault_o` then stays high until reset, and the count stops changing except through R4.
- R6: A clock edge with `cyc_stb`=0 leaves the count unchanged, whatever `thr_cross` is.
- R7: `shutdown_o` equals `fault_o` on every cycle.
- R8: Crossing and non-crossing strobes that alternate never set the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| det_en | input | 1 | Detector enable; low during ignition |
| cyc_stb | input | 1 | One-cycle pulse per switching cycle |
| thr_cross | input | 1 | Comparator result: the open-lamp drop was crossed this cycle |
| fault_o | output | 1 | Sticky open-lamp fault flag |
| shutdown_o | output | 1 | Output-stage shutdown request |

## Verification
The assertions check the following on every cycle:
- the count sits at zero after a disabled edge;
- the count stays at zero when it decrements at zero;
- the count holds when there is no strobe;
- the fault, once set, stays set;
- a crossing at the maximum count sets the fault;
- the shutdown output matches the fault flag.

The count is not visible at the ports. The bench's scenarios show it indirectly, by counting exactly how many crossing strobes are still needed before the fault appears after:
- decrements;
- saturation at zero;
- gaps with no strobe;
- a disable pulse.

The scenarios also show that alternating dips never trip the fault and that the fault survives a disable.

// File: rtl/olp_pkg.sv
// Shared types for the open-lamp fault detector.
// Assumes: one count step at most per clock.
package olp_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_UP    = 2'd1,
        STEP_DOWN  = 2'd2,
        STEP_CLEAR = 2'd3
    } step_e;
endpackage

// File: rtl/olp_step_dec.sv
// Chooses the counter action for this clock from the qualifiers.
// Assumes: the strobe is already synchronous to clk.
module olp_step_dec
    import olp_pkg::*;
(
    input  logic  det_en,
    input  logic  cyc_stb,
    input  logic  thr_cross,
    input  logic  fault,
    output step_e step
);
    // Priority: disable clears, then fault or missing strobe hold.
    always_comb begin
        if (!det_en)
            step = STEP_CLEAR;
        else if (fault || !cyc_stb)
            step = STEP_HOLD;
        else if (thr_cross)
            step = STEP_UP;
        else
            step = STEP_DOWN;
    end
endmodule

// File: rtl/olp_updown_cnt.sv
// Saturating up/down counter that flags an up step taken from the top value.
// Assumes: the step comes from olp_step_dec; synchronous active-low reset.
module olp_updown_cnt
    import olp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Overflow is an up request made while the count is at its top value.
    assign ovf = (step == STEP_UP) && (cnt == CNT_MAX);

    // Count update with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (step)
                STEP_CLEAR: cnt <= '0;
                STEP_UP:    if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                STEP_DOWN:  if (cnt != '0) cnt <= cnt - 1'b1;
                default:    cnt <= cnt;
            endcase
        end
    end

    p_down_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_DOWN && cnt == '0) |=> (cnt == '0));
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_CLEAR) |=> (cnt == '0));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_HOLD) |=> $stable(cnt));
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_UP && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/olp_fault_latch.sv
// Sticky fault flag. It sets on counter overflow and clears only through reset.
// Assumes: rst_n reflects a power cycle.
module olp_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic fault
);
    // Latch the overflow. Nothing except reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault <= 1'b0;
        else if (set_i)
            fault <= 1'b1;
    end

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
endmodule

// File: rtl/olp_guard.sv
// Open-lamp fault detector. It integrates per-cycle threshold crossings in an
// up/down counter and latches a shutdown when the counter overflows.
// Assumes: cyc_stb pulses once per switching cycle; det_en is low during ignition.
module olp_guard
    import olp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic cyc_stb,
    input  logic thr_cross,
    output logic fault_o,
    output logic shutdown_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    step_e            step;
    logic [CNT_W-1:0] cnt;
    logic             ovf;
    logic             fault;

    olp_step_dec u_dec (
        .det_en   (det_en),
        .cyc_stb  (cyc_stb),
        .thr_cross(thr_cross),
        .fault    (fault),
        .step     (step)
    );

    olp_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .step (step),
        .cnt  (cnt),
        .ovf  (ovf)
    );

    olp_fault_latch u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(ovf),
        .fault(fault)
    );

    // The same latched flag drives both outputs.
    assign fault_o    = fault;
    assign shutdown_o = fault;

    p_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && cyc_stb && thr_cross && cnt == TOP) |=> fault_o);
    p_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && cyc_stb && thr_cross && !fault && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!fault_o && cnt == '0));

    // R7: the shutdown request always matches the fault flag.
    always_comb begin
        p_shut_r7: assert (shutdown_o == fault_o);
    end
endmodule

// File: tb/sim_olp_guard.sv
module sim_olp_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_en = 1'b0;
    logic cyc_stb = 1'b0;
    logic thr_cross = 1'b0;
    logic fault_o;
    logic shutdown_o;

    int checks = 0;
    int failures = 0;
    int m_cnt = 0;
    bit m_fault = 0;

    always #10 clk = ~clk;

    olp_guard u0 (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .cyc_stb(cyc_stb),
        .thr_cross(thr_cross), .fault_o(fault_o), .shutdown_o(shutdown_o)
    );

    task automatic chk(input string req, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One clock: drive inputs, advance the behavioural model, compare at negedge.
    task automatic cyc(input bit r, input bit en, input bit stb, input bit cr);
        rst_n = r; det_en = en; cyc_stb = stb; thr_cross = cr;
        @(posedge clk);
        if (!r) begin
            m_cnt = 0; m_fault = 0;
        end else if (!en) begin
            m_cnt = 0;
        end else if (!m_fault && stb) begin
            if (cr) begin
                if (m_cnt == 15) m_fault = 1; else m_cnt++;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end
        end
        @(negedge clk);
        chk("R5 model", fault_o, m_fault);
        chk("R7 mirror", shutdown_o, fault_o);
    endtask

    task automatic ups(input int n);
        for (int i = 0; i < n; i++) cyc(1, 1, 1, 1);
    endtask

    task automatic do_reset();
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        chk("R1 reset fault", fault_o, 1'b0);
        chk("R1 reset shutdown", shutdown_o, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R2/R3/R5: 15 ups, one down, one up, then the tripping up.
        ups(15);
        chk("R2 fifteen ups no fault", fault_o, 1'b0);
        cyc(1, 1, 1, 0);
        ups(1);
        chk("R3 decrement delays trip", fault_o, 1'b0);
        ups(1);
        chk("R5 trip on up from max", fault_o, 1'b1);
        chk("R7 shutdown set", shutdown_o, 1'b1);
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0);
        chk("R4 disable keeps fault", fault_o, 1'b1);
        do_reset();

        // R3: downs at zero saturate.
        for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0);
        ups(15);
        chk("R3 saturation at zero", fault_o, 1'b0);
        ups(1);
        chk("R3 trip after saturation", fault_o, 1'b1);
        do_reset();

        // R6: crossings without a strobe do not count.
        ups(15);
        for (int i = 0; i < 10; i++) cyc(1, 1, 0, 1);
        chk("R6 no strobe no count", fault_o, 1'b0);
        ups(1);
        chk("R6 count held across gap", fault_o, 1'b1);
        do_reset();

        // R4: a disable pulse clears the count.
        ups(15);
        cyc(1, 0, 1, 1);
        ups(15);
        chk("R4 disable clears count", fault_o, 1'b0);
        ups(1);
        chk("R4 trip after full recount", fault_o, 1'b1);
        do_reset();

        // R8: alternating dips never trip.
        for (int i = 0; i < 100; i++) begin
            cyc(1, 1, 1, 1);
            cyc(1, 1, 1, 0);
        end
        chk("R8 alternating no fault", fault_o, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule